// File: doc/BRIEF.md
# Four-Mode Dual Timer/Counter

This block holds two timer/counter channels. Each channel keeps a count as a low byte and a high byte. A per-channel mode field chooses how those bytes count:

- **M_PRESC13**: a 13-bit count built from a 5-bit low part and the whole high byte.
- **M_FULL16**: a 16-bit count.
- **M_RELOAD8**: an 8-bit count that reloads itself from the high byte.
- **M_SPLIT**: on channel 0, two independent 8-bit counters. On channel 1, the count is frozen.

A channel steps only when three things hold: its run bit is set, its gate condition passes, and its selected source fires. The source is either the machine-cycle enable pulse or a falling edge on the channel's count pin. A small register port lets software write and read the control byte, the mode byte and the four count bytes. The two overflow flags are the block's only results. A flag stays set until software writes it to 0 or the matching acknowledge input is pulsed.

Each count pin passes through a synchronizer and then into a two-state machine.

- State **EDGE_LOW** is the reset state. It moves to **EDGE_HIGH** when the synchronized pin reads 1. That is the *rise* transition.
- State **EDGE_HIGH** moves back to **EDGE_LOW** when the synchronized pin reads 0. That is the *fall* transition, and only this transition produces a count event.

Because the machine resets into EDGE_LOW, a pin that is already low after reset causes no count.

In the split mode of channel 0:

- The high byte becomes a machine-cycle timer that uses channel 1's run bit and channel 1's flag.
- Channel 1 then runs whenever its own mode is not M_SPLIT. Its overflow sets no flag.

Top module: `dual_tmr_top`

## Requirements
- R1: After reset, every readable byte is 0x00 and both flags are 0.
- R2: In M_PRESC13, bits 4:0 of the low byte count and carry into the high byte. Low-byte bits 7:5 keep their written value. Passing from 0xFF/0x1F to zero sets the channel's flag.
- R3: In M_FULL16, {high, low} steps by 1. Wrapping from 0xFFFF to 0x0000 sets the channel's flag.
- R4: A channel steps only when its run bit is 1 and either its gate bit is 0 or its gate pin is 1.
- R5: With the run bit at 0, the count holds. Setting the run bit again does not clear the count.
- R6: In M_RELOAD8, the low byte steps. On 0xFF it is reloaded from the high byte and the flag is set. The high byte never changes except by a write.
- R7: With the source-select bit at 0, the count steps once per cycle in which mc_tick is 1. With the bit at 1, it steps once per falling edge of the count pin, seen after a 2-flop synchronizer, and mc_tick is ignored.
- R8: Channel 1 in M_SPLIT holds its count whatever its run bit is.
- R9: Channel 0 in M_SPLIT splits its count into two halves.
  - The low byte is an 8-bit counter using channel 0's controls and flag.
  - The high byte steps on mc_tick while channel 1's run bit is 1, and sets channel 1's flag on wrap.
  - Channel 1 then ignores its run bit, and its overflow sets no flag.
- R10: A flag stays 1 until a control write puts 0 in its bit or its ack input is 1 for a cycle. An overflow in the same cycle wins over both.
- R11: A write to a count byte in the same cycle as a step stores the written value, and that channel's step is dropped.
- R12: The register map and bit layouts are as follows.
  - Address map: 0 control, 1 mode, 2 ch0 low, 3 ch0 high, 4 ch1 low, 5 ch1 high. Addresses 6 and 7 read 0.
  - Control byte, bit 7 down to bit 4: flag1, run1, flag0, run0. Bits 3:0 read 0 and ignore writes.
  - Mode byte: bit 7 gate1, bit 6 source1, bits 5:4 mode1, bit 3 gate0, bit 2 source0, bits 1:0 mode0.
  - Mode codes: 0 M_PRESC13, 1 M_FULL16, 2 M_RELOAD8, 3 M_SPLIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | Machine-cycle enable pulse used by timer mode |
| cnt_pin | input | 2 | External count pins, one per channel |
| gate_pin | input | 2 | External gate pins, one per channel |
| ack | input | 2 | Flag acknowledge, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| tf | output | 2 | Overflow flags, bit 1 for channel 1 |

## Verification
The bench targets the following corner cases:

- **Prescaled carry:** a design that carried out of the wrong bit, or cleared the three unused low bits, would show a wrong low byte after 33 steps.
- **Reload:** a design that reloaded to zero, or let the high byte move, would read back something other than 0xF0 and 0xF3.
- **Split mode:** the bench checks that the high half answers to channel 1's run bit, and that channel 1 keeps counting but stays silent. A design that routed flags the old way would set the wrong flag or none at all.
- **Same-cycle write and step:** this case exposes a design that lets the increment win.
- **Counter mode:** this case exposes one that counts on ticks or on rising edges.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        M_PRESC13 = 2'd0,
        M_FULL16  = 2'd1,
        M_RELOAD8 = 2'd2,
        M_SPLIT   = 2'd3
    } tmode_e;

    typedef enum logic {
        EDGE_LOW  = 1'b0,
        EDGE_HIGH = 1'b1
    } edge_st_e;

    typedef struct packed {
        logic   gate;
        logic   src_ext;
        tmode_e mode;
    } chan_cfg_t;

    localparam int unsigned CFG_W   = $bits(chan_cfg_t);
    localparam int unsigned REG_AW  = 3;
    localparam int unsigned NUM_CH  = 2;

    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_MODE = 3'd1;
    localparam int unsigned       A_CNT_BASE = 2;

endpackage

// File: rtl/dtc_edge_det.sv
module dtc_edge_det
    import dtc_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    edge_st_e               st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EDGE_LOW:  if (pin_s)  st_d = EDGE_HIGH;
            EDGE_HIGH: if (!pin_s) st_d = EDGE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDGE_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        fall = (st_q == EDGE_HIGH) && !pin_s;
    end

    // R7: one event per falling edge, never two cycles in a row
    p_fall_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/dtc_count_unit.sv
module dtc_count_unit
    import dtc_pkg::*;
#(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned PRE_W    = 5,
    parameter bit          SPLIT_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmode_e            mode,
    input  logic              step_lo,
    input  logic              step_hi,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q,
    output logic              ovf_lo,
    output logic              ovf_hi
);

    localparam int unsigned CW = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_d, hi_d;
    logic [CW-1:0]     full_inc;
    logic              wr_any;

    assign wr_any   = wr_lo || wr_hi;
    assign full_inc = {hi_q, lo_q} + CW'(1);

    always_comb begin
        lo_d   = lo_q;
        hi_d   = hi_q;
        ovf_lo = 1'b0;
        ovf_hi = 1'b0;
        unique case (mode)
            M_PRESC13: begin
                if (step_lo && !wr_any) begin
                    if (lo_q[PRE_W-1:0] == '1) begin
                        lo_d[PRE_W-1:0] = '0;
                        hi_d            = hi_q + BYTE_W'(1);
                        ovf_lo          = (hi_q == '1);
                    end else begin
                        lo_d[PRE_W-1:0] = lo_q[PRE_W-1:0] + PRE_W'(1);
                    end
                end
            end
            M_FULL16: begin
                if (step_lo && !wr_any) begin
                    {hi_d, lo_d} = full_inc;
                    ovf_lo       = ({hi_q, lo_q} == '1);
                end
            end
            M_RELOAD8: begin
                if (step_lo && !wr_any) begin
                    if (lo_q == '1) begin
                        lo_d   = hi_q;
                        ovf_lo = 1'b1;
                    end else begin
                        lo_d   = lo_q + BYTE_W'(1);
                    end
                end
            end
            M_SPLIT: begin
                if (SPLIT_OK) begin
                    if (step_lo && !wr_lo) begin
                        lo_d   = lo_q + BYTE_W'(1);
                        ovf_lo = (lo_q == '1);
                    end
                    if (step_hi && !wr_hi) begin
                        hi_d   = hi_q + BYTE_W'(1);
                        ovf_hi = (hi_q == '1);
                    end
                end
            end
        endcase
        if (wr_lo) lo_d = wr_data;
        if (wr_hi) hi_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    // R2: counting never touches the unused low-byte bits
    p_upper_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PRESC13 && !wr_lo) |=> $stable(lo_q[BYTE_W-1:PRE_W]));

    // R3: full wrap lands on zero
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_FULL16 && step_lo && !wr_any && {hi_q, lo_q} == '1)
        |=> ({hi_q, lo_q} == '0));

    // R6: reload mode leaves the high byte alone
    p_hi_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_RELOAD8 && !wr_hi) |=> $stable(hi_q));

    // R11: a written byte holds the written value next cycle
    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_q == $past(wr_data)));

endmodule

// File: rtl/dual_tmr_top.sv
module dual_tmr_top
    import dtc_pkg::*;
#(
    parameter int unsigned BYTE_W      = 8,
    parameter int unsigned PRE_W       = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic [1:0]        cnt_pin,
    input  logic [1:0]        gate_pin,
    input  logic [1:0]        ack,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic [1:0]        tf
);

    logic [NUM_CH-1:0] tf_q, tf_d, tr_q;
    chan_cfg_t         cfg_q [NUM_CH];
    logic              wr_ctrl, wr_mode, t0_split;
    logic [NUM_CH-1:0] fall, gate_ok, src_ev, run_eff;
    logic [NUM_CH-1:0] step_lo, step_hi, wr_lo, wr_hi, ovf_lo, ovf_hi, set_ev;
    logic [BYTE_W-1:0] cnt_lo [NUM_CH];
    logic [BYTE_W-1:0] cnt_hi [NUM_CH];

    assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign wr_mode  = wr_en && (wr_addr == A_MODE);
    assign t0_split = (cfg_q[0].mode == M_SPLIT);

    assign run_eff[0] = tr_q[0];
    assign run_eff[1] = t0_split ? 1'b1 : tr_q[1];

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            localparam int unsigned LO_A = A_CNT_BASE + 2 * g;
            localparam int unsigned HI_A = LO_A + 1;

            dtc_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk  (clk),
                .rst_n(rst_n),
                .pin  (cnt_pin[g]),
                .fall (fall[g])
            );

            assign gate_ok[g] = !cfg_q[g].gate || gate_pin[g];
            assign src_ev[g]  = cfg_q[g].src_ext ? fall[g] : mc_tick;
            assign step_lo[g] = run_eff[g] && gate_ok[g] && src_ev[g];
            assign wr_lo[g]   = wr_en && (wr_addr == REG_AW'(LO_A));
            assign wr_hi[g]   = wr_en && (wr_addr == REG_AW'(HI_A));

            if (g == 0) begin : g_split_src
                assign step_hi[g] = tr_q[1] && mc_tick;
            end else begin : g_no_split
                assign step_hi[g] = 1'b0;
            end

            dtc_count_unit #(
                .BYTE_W  (BYTE_W),
                .PRE_W   (PRE_W),
                .SPLIT_OK(g == 0)
            ) u_cnt (
                .clk    (clk),
                .rst_n  (rst_n),
                .mode   (cfg_q[g].mode),
                .step_lo(step_lo[g]),
                .step_hi(step_hi[g]),
                .wr_lo  (wr_lo[g]),
                .wr_hi  (wr_hi[g]),
                .wr_data(wr_data),
                .lo_q   (cnt_lo[g]),
                .hi_q   (cnt_hi[g]),
                .ovf_lo (ovf_lo[g]),
                .ovf_hi (ovf_hi[g])
            );
        end
    endgenerate

    assign set_ev[0] = ovf_lo[0];
    assign set_ev[1] = t0_split ? ovf_hi[0] : (ovf_lo[1] || ovf_hi[1]);

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            tf_d[i] = tf_q[i];
            if (wr_ctrl) tf_d[i] = wr_data[BYTE_W-3+2*i];
            if (ack[i])  tf_d[i] = 1'b0;
            if (set_ev[i]) tf_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tf_q  <= '0;
            tr_q  <= '0;
            cfg_q <= '{default: '0};
        end else begin
            tf_q <= tf_d;
            if (wr_ctrl) tr_q <= {wr_data[BYTE_W-2], wr_data[BYTE_W-4]};
            if (wr_mode) begin
                cfg_q[1] <= chan_cfg_t'(wr_data[2*CFG_W-1:CFG_W]);
                cfg_q[0] <= chan_cfg_t'(wr_data[CFG_W-1:0]);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            3'd0: rd_data[BYTE_W-1 -: 4] = {tf_q[1], tr_q[1], tf_q[0], tr_q[0]};
            3'd1: rd_data[2*CFG_W-1:0]   = {cfg_q[1], cfg_q[0]};
            3'd2: rd_data = cnt_lo[0];
            3'd3: rd_data = cnt_hi[0];
            3'd4: rd_data = cnt_lo[1];
            3'd5: rd_data = cnt_hi[1];
            default: rd_data = '0;
        endcase
    end

    assign tf = tf_q;

    // R10: an overflow always leaves its flag set
    p_flag_set0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[0] |=> tf[0]);
    p_flag_set1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev[1] |=> tf[1]);
    // R10: without a clear request a set flag stays set
    p_flag_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (tf[0] && !ack[0] && !wr_ctrl) |=> tf[0]);

    // R8: channel 1 frozen in split mode
    p_t1_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[1].mode == M_SPLIT && !wr_lo[1] && !wr_hi[1])
        |=> $stable({cnt_hi[1], cnt_lo[1]}));

    // R5: stopped channel 0 holds outside split mode
    p_run_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tr_q[0] && !t0_split && !wr_lo[0] && !wr_hi[0])
        |=> $stable({cnt_hi[0], cnt_lo[0]}));

endmodule

// File: tb/test_dual_tmr_top.sv
`timescale 1ns/1ps
module test_dual_tmr_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_tick = 1'b0;
    logic [1:0] cnt_pin = 2'b11;
    logic [1:0] gate_pin = 2'b00;
    logic [1:0] ack = 2'b00;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [1:0] tf;

    always #4 clk = ~clk;

    dual_tmr_top i_dual_tmr_top (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .ack(ack), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tf(tf)
    );

    typedef struct {
        logic [3:0] addr;
        logic [7:0] exp;
        string      tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    sb_item_t cur;
    int n_chk = 0, n_fail = 0, n_push = 0, n_done = 0;
    logic [7:0] act;
    bit finished = 0;

    // monitor: pops expected items and compares as results appear
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            cur = sb_q.pop_front();
            @(negedge clk);
            if (cur.addr < 8) rd_addr = cur.addr[2:0];
            #1;
            act = (cur.addr == 8) ? {6'b0, tf} : rd_data;
            n_chk++;
            if (act !== cur.exp) begin
                n_fail++;
                $display("FAIL %s addr %0d: actual %h expected %h",
                         cur.tag, cur.addr, act, cur.exp);
            end
            n_done++;
        end
    end

    task automatic expect_val(input logic [3:0] a, input logic [7:0] e, input string t);
        sb_item_t it;
        it.addr = a; it.exp = e; it.tag = t;
        sb_q.push_back(it);
        n_push++;
        wait (n_done == n_push);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(input int n);
        @(negedge clk);
        mc_tick = 1'b1;
        repeat (n) @(negedge clk);
        mc_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        finished = 1;
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) expect_val(4'(a), 8'h00, "R1");
        expect_val(8, 8'h00, "R1 flags");

        // R3 16-bit wrap, R12 control layout
        wr(1, 8'h01); wr(2, 8'hFE); wr(3, 8'hFF); wr(0, 8'h10);
        tick(1);
        expect_val(2, 8'hFF, "R3"); expect_val(3, 8'hFF, "R3"); expect_val(8, 8'h00, "R3");
        tick(1);
        expect_val(2, 8'h00, "R3"); expect_val(3, 8'h00, "R3"); expect_val(8, 8'h01, "R3");
        expect_val(0, 8'h30, "R12 ctrl");

        // R10 flag persistence and clearing
        tick(3);
        expect_val(8, 8'h01, "R10 held");
        @(negedge clk); ack = 2'b01; @(negedge clk); ack = 2'b00;
        expect_val(8, 8'h00, "R10 ack");
        wr(2, 8'hFF); wr(3, 8'hFF); tick(1);
        expect_val(8, 8'h01, "R10 set");
        wr(0, 8'h10);
        expect_val(8, 8'h00, "R10 write");

        // R5 run control
        wr(0, 8'h00); wr(2, 8'h55); wr(3, 8'h44);
        tick(4);
        expect_val(2, 8'h55, "R5 hold");
        wr(0, 8'h10);
        expect_val(2, 8'h55, "R5 no clear"); expect_val(3, 8'h44, "R5 no clear");
        tick(2);
        expect_val(2, 8'h57, "R5 resume");

        // R2 prescaled mode
        wr(0, 8'h00); wr(1, 8'h00); wr(2, 8'hFF); wr(3, 8'h12); wr(0, 8'h10);
        tick(1);
        expect_val(2, 8'hE0, "R2 carry"); expect_val(3, 8'h13, "R2 carry");
        tick(33);
        expect_val(2, 8'hE1, "R2 33 steps"); expect_val(3, 8'h14, "R2 33 steps");
        wr(0, 8'h00); wr(2, 8'h1F); wr(3, 8'hFF); wr(0, 8'h10);
        tick(1);
        expect_val(2, 8'h00, "R2 wrap"); expect_val(3, 8'h00, "R2 wrap");
        expect_val(8, 8'h01, "R2 flag");
        wr(0, 8'h00);

        // R4 gating
        wr(1, 8'h09); wr(2, 8'h00); wr(3, 8'h00);
        gate_pin = 2'b00; wr(0, 8'h10);
        tick(5);
        expect_val(2, 8'h00, "R4 gated");
        gate_pin = 2'b01;
        tick(5);
        expect_val(2, 8'h05, "R4 open");
        wr(0, 8'h00);
        tick(2);
        expect_val(2, 8'h05, "R4 run off");

        // R6 auto-reload on channel 1
        wr(1, 8'h20); wr(5, 8'hF0); wr(4, 8'hFE); wr(0, 8'h40);
        tick(2);
        expect_val(4, 8'hF0, "R6 reload"); expect_val(5, 8'hF0, "R6 hi");
        expect_val(8, 8'h02, "R6 flag");
        tick(3);
        expect_val(4, 8'hF3, "R6 after");
        wr(0, 8'h00);

        // R7 counter source
        wr(1, 8'h05); wr(2, 8'h00); wr(3, 8'h00); wr(0, 8'h10);
        tick(10);
        expect_val(2, 8'h00, "R7 ticks ignored");
        repeat (3) begin
            @(negedge clk); cnt_pin[0] = 1'b0;
            repeat (4) @(negedge clk);
            cnt_pin[0] = 1'b1;
            repeat (4) @(negedge clk);
        end
        expect_val(2, 8'h03, "R7 edges");
        wr(0, 8'h00);

        // R8 channel 1 frozen in split mode
        wr(1, 8'h30); wr(4, 8'h11); wr(5, 8'h22); wr(0, 8'h40);
        tick(5);
        expect_val(4, 8'h11, "R8"); expect_val(5, 8'h22, "R8"); expect_val(8, 8'h00, "R8");
        wr(0, 8'h00);

        // R9 split channel 0
        wr(1, 8'h13); wr(2, 8'hFF); wr(3, 8'hFE); wr(4, 8'h00); wr(5, 8'h00);
        wr(0, 8'h10);
        tick(1);
        expect_val(2, 8'h00, "R9 low"); expect_val(3, 8'hFE, "R9 hi needs run1");
        expect_val(4, 8'h01, "R9 ch1 free"); expect_val(8, 8'h01, "R9 flag0");
        wr(0, 8'h50);
        tick(2);
        expect_val(2, 8'h02, "R9 low"); expect_val(3, 8'h00, "R9 hi wrap");
        expect_val(4, 8'h03, "R9 ch1"); expect_val(8, 8'h02, "R9 flag1");
        wr(0, 8'h00); wr(4, 8'hFF); wr(5, 8'hFF);
        tick(1);
        expect_val(4, 8'h00, "R9 ch1 wrap"); expect_val(5, 8'h00, "R9 ch1 wrap");
        expect_val(8, 8'h00, "R9 ch1 silent");

        // R11 write beats step
        wr(1, 8'h01); wr(2, 8'h10); wr(3, 8'h00); wr(0, 8'h10);
        @(negedge clk); mc_tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h80;
        @(negedge clk); mc_tick = 1'b0; wr_en = 1'b0;
        expect_val(2, 8'h80, "R11"); expect_val(3, 8'h00, "R11");
        tick(1);
        expect_val(2, 8'h81, "R11 after");

        // R12 unused bits and addresses
        wr(0, 8'h1F);
        expect_val(0, 8'h10, "R12 low nibble");
        expect_val(6, 8'h00, "R12 addr6");
        expect_val(7, 8'h00, "R12 addr7");

        finish_run();
    end

endmodule